// File: doc/BRIEF.md
# Erased Codeword Detector with Marker Fixup

This block inspects one codeword at a time after the error-correction engine has reported it as uncorrectable. It decides whether the codeword is in fact an erased, all-ones chunk rather than damaged data. Bytes arrive on a valid/ready stream with first and last flags. The block stores the whole codeword, produces a verdict and a zero-bit count, and then replays the codeword on a second valid/ready stream.

Two rules decide the verdict. The first rule depends on the `mode` input. In Reed-Solomon mode the engine marks an erased chunk by placing the value 0x54 at one of two fixed byte offsets, 3 and 175. The block recognises this marker, treats the marker positions as 0xFF, and rewrites them to 0xFF in the replayed stream, but only when the rest of the data is all ones. In BCH mode the markers mean nothing, and an external erased-status word gives the first rule's answer. The second rule tolerates bit flips: it counts the zero bits in the protected bytes and accepts the chunk when that count does not exceed a programmable strength.

Each codeword is sent exactly `CW_LEN` bytes long. The data bytes occupy offsets 0 to `DATA_LEN`-1. A usable spare window follows the bad-block byte.

Top module: `erased_cw_checker`

## Requirements
- R1: While reset is held, and in the first cycle after it, `res_valid` and `out_valid` are 0. After reset `in_ready` is 1.
- R2: `in_ready` stays 1 until the byte flagged last (offset `CW_LEN`-1) is accepted, then drops to 0 until the whole codeword has been replayed. The replay starts in the next cycle with `out_first` set on offset 0 and `out_last` set on offset `CW_LEN`-1. While `out_valid` is 1 and `out_ready` is 0, `out_data` holds its value.
- R3: `res_valid` is a one-cycle pulse in the cycle that follows the acceptance of the last input byte. `res_erased` and `res_zero_cnt` are valid in that cycle.
- R4: `res_zero_cnt` is the number of 0 bits in offsets 0..`DATA_LEN`-1 and in the usable spare window `SPARE_OFS`..`SPARE_OFS+SPARE_LEN`-1 (default 513..516). The bad-block byte at offset `DATA_LEN` and all bytes above the spare window do not count.
- R5: `res_zero_cnt` saturates at 255.
- R6: In Reed-Solomon mode (`mode`=0), a marker pair means one of offsets 3 and 175 holds 0x54 and the other holds 0xFF. Marker bytes then add no zeros to the count. If every other data byte is 0xFF, the chunk is erased and both marker offsets are replayed as 0xFF.
- R7: In Reed-Solomon mode, when a valid marker pair is present but some other data byte is not 0xFF, the replay carries the original bytes at offsets 3 and 175.
- R8: In Reed-Solomon mode, any other values at offsets 3 and 175 (for example 0x54 at both) are not a marker pair. Those bytes are counted like any other byte and are replayed unchanged.
- R9: In BCH mode (`mode`=1), the values at offsets 3 and 175 have no special meaning: they are counted and replayed unchanged. The first rule passes only if every bit of `erased_status`, sampled with the last byte, is 1.
- R10: `res_erased` is 1 when the first rule passes, or when `res_zero_cnt` is at most `ecc_strength` (sampled with the last byte). Otherwise it is 0. Only a pass of the first rule rewrites the markers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 1 | 0 = Reed-Solomon marker rule, 1 = BCH status rule |
| ecc_strength | input | 8 | Highest zero count still accepted as erased |
| erased_status | input | ST_W | Erased-status bits from the decoder, used in BCH mode |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block can accept an input byte |
| in_data | input | 8 | Input byte |
| in_first | input | 1 | Input byte is offset 0 |
| in_last | input | 1 | Input byte is offset CW_LEN-1 |
| out_valid | output | 1 | Replay byte valid |
| out_ready | input | 1 | Receiver takes the replay byte |
| out_data | output | 8 | Replay byte, markers rewritten when fixed up |
| out_first | output | 1 | Replay byte is offset 0 |
| out_last | output | 1 | Replay byte is offset CW_LEN-1 |
| res_valid | output | 1 | Verdict pulse |
| res_erased | output | 1 | Codeword judged erased |
| res_zero_cnt | output | 8 | Saturated zero-bit count |

## Verification
The assertions assume a framing contract on the input stream: every codeword is exactly `CW_LEN` bytes long, `in_first` comes only with offset 0, and `in_last` comes only with offset `CW_LEN`-1. The assertions also assume that `ecc_strength` and `erased_status` are meaningful in the cycle the last byte is taken. The bench keeps to this contract. It always drives whole codewords with correct flags, and it holds the strength and status steady for the entire codeword. Within that contract the stimulus varies the marker values, the excluded regions, saturation, the mode and output backpressure.

// File: rtl/ecd_pkg.sv
// Package: shared types and helpers for the erased codeword detector.
// Assumes byte-wide data; counts fit in eight bits after saturation.
package ecd_pkg;

    typedef enum logic {
        ECD_RS  = 1'b0,
        ECD_BCH = 1'b1
    } ecd_mode_e;

    localparam logic [7:0] ERASED_BYTE = 8'hFF;
    localparam logic [7:0] RS_MARK     = 8'h54;

    // Number of zero bits in one byte.
    function automatic logic [3:0] zeros_in(input logic [7:0] b);
        logic [3:0] n;
        n = 4'd0;
        for (int k = 0; k < 8; k++) begin
            n = n + {3'd0, ~b[k]};
        end
        return n;
    endfunction

    // Add a small value to a count, saturating at 255.
    function automatic logic [7:0] sat_add8(input logic [7:0] a, input logic [4:0] b);
        logic [8:0] s;
        s = {1'b0, a} + {4'd0, b};
        return s[8] ? 8'hFF : s[7:0];
    endfunction

endpackage

// File: rtl/ecd_cw_buffer.sv
// Module: ecd_cw_buffer
// Stores one complete codeword and then replays it. During the replay the
// two marker offsets can be forced to 0xFF. Input and output phases never
// overlap. Assumes each codeword is exactly CW_LEN bytes long, and that the
// fixup input is stable from the cycle after the last byte until replay ends.
module ecd_cw_buffer #(
    parameter int CW_LEN = 528,
    parameter int MARK_A = 3,
    parameter int MARK_B = 175,
    parameter int IW     = $clog2(CW_LEN + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [7:0]    in_data,
    input  logic          in_last,
    output logic          in_ready,
    output logic          take,
    output logic [IW-1:0] idx,
    input  logic          fixup,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [7:0]    out_data,
    output logic          out_first,
    output logic          out_last
);
    import ecd_pkg::*;

    localparam logic [IW-1:0] LAST_IDX = IW'(CW_LEN - 1);
    localparam logic [IW-1:0] MA_IDX   = IW'(MARK_A);
    localparam logic [IW-1:0] MB_IDX   = IW'(MARK_B);

    logic [7:0]    mem [CW_LEN];
    logic          emit_q;
    logic [IW-1:0] wr_q;
    logic [IW-1:0] rd_q;
    logic          give;
    logic          at_mark;

    assign in_ready  = !emit_q;
    assign take      = in_valid && in_ready;
    assign idx       = wr_q;
    assign give      = out_valid && out_ready;
    assign out_valid = emit_q;
    assign at_mark   = (rd_q == MA_IDX) || (rd_q == MB_IDX);
    assign out_data  = (fixup && at_mark) ? ERASED_BYTE : mem[rd_q];
    assign out_first = emit_q && (rd_q == '0);
    assign out_last  = emit_q && (rd_q == LAST_IDX);

    // Byte storage: write each accepted byte at its offset.
    always_ff @(posedge clk) begin
        if (take) begin
            mem[wr_q] <= in_data;
        end
    end

    // Phase control: fill pointer, replay pointer and phase flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            emit_q <= 1'b0;
            wr_q   <= '0;
            rd_q   <= '0;
        end else if (take) begin
            if (in_last) begin
                wr_q   <= '0;
                rd_q   <= '0;
                emit_q <= 1'b1;
            end else begin
                wr_q <= wr_q + 1'b1;
            end
        end else if (give) begin
            if (rd_q == LAST_IDX) begin
                emit_q <= 1'b0;
                rd_q   <= '0;
            end else begin
                rd_q <= rd_q + 1'b1;
            end
        end
    end

    // A stalled replay byte must stay put.
    assert_out_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    // The replay begins right after the last byte is taken.
    assert_replay_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        take && in_last |=> out_valid && out_first && !in_ready);

endmodule

// File: rtl/ecd_marker_judge.sv
// Module: ecd_marker_judge
// Applies the mode-dependent first rule. In Reed-Solomon mode it captures
// the two marker bytes and tracks whether every other data byte is 0xFF.
// In BCH mode it checks the external status word instead. Its final outputs
// are combinational and valid while the last byte is taken. The fixup flag
// is registered for the replay. Assumes both markers lie in the data region.
module ecd_marker_judge #(
    parameter int DATA_LEN = 512,
    parameter int MARK_A   = 3,
    parameter int MARK_B   = 175,
    parameter int ST_W     = 8,
    parameter int IW       = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            take,
    input  logic [IW-1:0]   idx,
    input  logic [7:0]      data,
    input  logic            last,
    input  logic            bch,
    input  logic [ST_W-1:0] status,
    output logic            fin_pattern,
    output logic            fin_strict,
    output logic            fixup_q
);
    import ecd_pkg::*;

    localparam logic [IW-1:0] DATA_END = IW'(DATA_LEN);
    localparam logic [IW-1:0] MA_IDX   = IW'(MARK_A);
    localparam logic [IW-1:0] MB_IDX   = IW'(MARK_B);

    logic [7:0] ma_q, mb_q, ma_n, mb_n;
    logic       oth_q, oth_n;
    logic       is_mark, in_data_rgn;
    logic       pair_ok, both_ff, fin_fixup;

    assign is_mark     = (idx == MA_IDX) || (idx == MB_IDX);
    assign in_data_rgn = idx < DATA_END;

    // Next values of the marker captures and of the all-ones tracker.
    always_comb begin
        ma_n  = (take && idx == MA_IDX) ? data : ma_q;
        mb_n  = (take && idx == MB_IDX) ? data : mb_q;
        oth_n = oth_q;
        if (take && in_data_rgn && !is_mark && data != ERASED_BYTE) begin
            oth_n = 1'b0;
        end
    end

    // Final decision terms, using the byte being taken.
    always_comb begin
        pair_ok     = (ma_n == RS_MARK && mb_n == ERASED_BYTE) ||
                      (ma_n == ERASED_BYTE && mb_n == RS_MARK);
        both_ff     = (ma_n == ERASED_BYTE) && (mb_n == ERASED_BYTE);
        fin_pattern = !bch && pair_ok;
        fin_strict  = bch ? (&status) : (oth_n && (pair_ok || both_ff));
        fin_fixup   = !bch && pair_ok && oth_n;
    end

    // Per-codeword state: captures, tracker, and the fixup flag for replay.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ma_q    <= ERASED_BYTE;
            mb_q    <= ERASED_BYTE;
            oth_q   <= 1'b1;
            fixup_q <= 1'b0;
        end else if (take) begin
            ma_q  <= ma_n;
            mb_q  <= mb_n;
            oth_q <= last ? 1'b1 : oth_n;
            if (last) begin
                fixup_q <= fin_fixup;
            end
        end
    end

    // In BCH mode the marker bytes are never rewritten.
    assert_bch_no_fixup_R9: assert property (@(posedge clk) disable iff (!rst_n)
        take && last && bch |=> !fixup_q);

    // A rewrite needs an all-ones status of the data around the markers.
    assert_fixup_needs_ones_R7: assert property (@(posedge clk) disable iff (!rst_n)
        take && last && !oth_n |=> !fixup_q);

endmodule

// File: rtl/ecd_zero_tally.sv
// Module: ecd_zero_tally
// Counts zero bits over the protected data and the usable spare window, with
// saturation at 255. Marker bytes are held aside until the end, so that a
// valid Reed-Solomon marker pair can be left out of the count. The final
// count is combinational while the last byte is taken. Assumes both markers
// lie in the data region.
module ecd_zero_tally #(
    parameter int DATA_LEN  = 512,
    parameter int SPARE_OFS = 513,
    parameter int SPARE_LEN = 4,
    parameter int MARK_A    = 3,
    parameter int MARK_B    = 175,
    parameter int IW        = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  logic [IW-1:0] idx,
    input  logic [7:0]    data,
    input  logic          last,
    input  logic          skip_marks,
    output logic [7:0]    fin_count
);
    import ecd_pkg::*;

    localparam logic [IW-1:0] DATA_END = IW'(DATA_LEN);
    localparam logic [IW-1:0] MA_IDX   = IW'(MARK_A);
    localparam logic [IW-1:0] MB_IDX   = IW'(MARK_B);

    logic [7:0] body_q, body_n;
    logic [3:0] mza_q, mzb_q, mza_n, mzb_n;
    logic [3:0] zc;
    logic       in_spare, counted, is_mark;

    // Spare window decode, present only when the window is non-empty.
    generate
        if (SPARE_LEN > 0) begin : g_spare
            localparam logic [IW-1:0] SP_LO = IW'(SPARE_OFS);
            localparam logic [IW-1:0] SP_HI = IW'(SPARE_OFS + SPARE_LEN);
            assign in_spare = (idx >= SP_LO) && (idx < SP_HI);
        end else begin : g_nospare
            assign in_spare = 1'b0;
        end
    endgenerate

    assign zc      = zeros_in(data);
    assign counted = (idx < DATA_END) || in_spare;
    assign is_mark = (idx == MA_IDX) || (idx == MB_IDX);

    // Next running count and marker zero counts.
    always_comb begin
        body_n = body_q;
        if (take && counted && !is_mark) begin
            body_n = sat_add8(body_q, {1'b0, zc});
        end
        mza_n = (take && idx == MA_IDX) ? zc : mza_q;
        mzb_n = (take && idx == MB_IDX) ? zc : mzb_q;
    end

    // Final count, with marker zeros added unless the marker pair is valid.
    assign fin_count = skip_marks ? body_n :
                       sat_add8(body_n, {1'b0, mza_n} + {1'b0, mzb_n});

    // Running state, cleared when a codeword ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            body_q <= 8'd0;
            mza_q  <= 4'd0;
            mzb_q  <= 4'd0;
        end else if (take) begin
            body_q <= last ? 8'd0 : body_n;
            mza_q  <= mza_n;
            mzb_q  <= mzb_n;
        end
    end

    // Within a codeword the count can only grow.
    assert_count_grows_R4: assert property (@(posedge clk) disable iff (!rst_n)
        take && !last |=> body_q >= $past(body_q));

    // A byte with no zeros leaves the running count unchanged.
    assert_ones_add_nothing_R4: assert property (@(posedge clk) disable iff (!rst_n)
        take && !last && data == 8'hFF |=> body_q == $past(body_q));

endmodule

// File: rtl/erased_cw_checker.sv
// Module: erased_cw_checker (top)
// Decides whether a codeword that failed correction is really erased. It
// combines the mode-dependent first rule with a zero-bit tolerance, and
// replays the codeword with the Reed-Solomon markers fixed up when the first
// rule passes. Assumes exact-length codewords with first and last flags on
// offsets 0 and CW_LEN-1, and that strength and status are valid with the
// last byte.
module erased_cw_checker #(
    parameter int CW_LEN    = 528,
    parameter int DATA_LEN  = 512,
    parameter int SPARE_OFS = 513,
    parameter int SPARE_LEN = 4,
    parameter int MARK_A    = 3,
    parameter int MARK_B    = 175,
    parameter int ST_W      = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mode,
    input  logic [7:0]      ecc_strength,
    input  logic [ST_W-1:0] erased_status,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic [7:0]      in_data,
    input  logic            in_first,
    input  logic            in_last,
    output logic            out_valid,
    input  logic            out_ready,
    output logic [7:0]      out_data,
    output logic            out_first,
    output logic            out_last,
    output logic            res_valid,
    output logic            res_erased,
    output logic [7:0]      res_zero_cnt
);
    import ecd_pkg::*;

    localparam int IW = $clog2(CW_LEN + 1);
    localparam logic [IW-1:0] LAST_IDX = IW'(CW_LEN - 1);

    ecd_mode_e     md;
    logic          bch;
    logic          take;
    logic [IW-1:0] idx;
    logic          fin_pattern, fin_strict, fixup_q;
    logic [7:0]    fin_count;

    assign md  = ecd_mode_e'(mode);
    assign bch = (md == ECD_BCH);

    ecd_cw_buffer #(
        .CW_LEN(CW_LEN), .MARK_A(MARK_A), .MARK_B(MARK_B), .IW(IW)
    ) u_buf (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
        .in_ready(in_ready), .take(take), .idx(idx),
        .fixup(fixup_q),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_first(out_first), .out_last(out_last)
    );

    ecd_marker_judge #(
        .DATA_LEN(DATA_LEN), .MARK_A(MARK_A), .MARK_B(MARK_B),
        .ST_W(ST_W), .IW(IW)
    ) u_judge (
        .clk(clk), .rst_n(rst_n),
        .take(take), .idx(idx), .data(in_data), .last(in_last),
        .bch(bch), .status(erased_status),
        .fin_pattern(fin_pattern), .fin_strict(fin_strict), .fixup_q(fixup_q)
    );

    ecd_zero_tally #(
        .DATA_LEN(DATA_LEN), .SPARE_OFS(SPARE_OFS), .SPARE_LEN(SPARE_LEN),
        .MARK_A(MARK_A), .MARK_B(MARK_B), .IW(IW)
    ) u_tally (
        .clk(clk), .rst_n(rst_n),
        .take(take), .idx(idx), .data(in_data), .last(in_last),
        .skip_marks(fin_pattern), .fin_count(fin_count)
    );

    // Verdict register: one pulse per codeword, with the combined rule.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid    <= 1'b0;
            res_erased   <= 1'b0;
            res_zero_cnt <= 8'd0;
        end else begin
            res_valid <= take && in_last;
            if (take && in_last) begin
                res_erased   <= fin_strict || (fin_count <= ecc_strength);
                res_zero_cnt <= fin_count;
            end
        end
    end

    // Input framing contract: flags sit on the expected offsets.
    assert_first_at_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && in_first |-> idx == '0);
    assert_last_at_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && in_last |-> idx == LAST_IDX);

    // The verdict follows the last byte by one cycle and lasts one cycle.
    assert_result_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(in_valid && in_ready && in_last));
    assert_result_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    // A rejected chunk always has more zeros than the strength allows.
    assert_tolerance_R10: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && !res_erased |-> res_zero_cnt > $past(ecc_strength));

    // In BCH mode a fully set status word means erased.
    assert_bch_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && in_last && mode && (&erased_status) |=> res_erased);

endmodule

// File: tb/erased_cw_checker_test.sv
// Directed bench: one task per scenario. Each task builds a codeword,
// predicts the verdict and the replay from the requirements, then checks them.
module erased_cw_checker_test;

    localparam int CW = 528;
    localparam int DL = 512;
    localparam int SO = 513;
    localparam int SL = 4;
    localparam int MA = 3;
    localparam int MB = 175;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode = 1'b0;
    logic [7:0] ecc_strength = 8'd0;
    logic [7:0] erased_status = 8'd0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_data = 8'd0;
    logic       in_first = 1'b0;
    logic       in_last = 1'b0;
    logic       out_valid;
    logic       out_ready = 1'b0;
    logic [7:0] out_data;
    logic       out_first;
    logic       out_last;
    logic       res_valid;
    logic       res_erased;
    logic [7:0] res_zero_cnt;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    logic [7:0] stim [CW];
    int unsigned lcg = 32'h1234_5678;

    erased_cw_checker uut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .ecc_strength(ecc_strength),
        .erased_status(erased_status),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_first(in_first), .in_last(in_last),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_first(out_first), .out_last(out_last),
        .res_valid(res_valid), .res_erased(res_erased), .res_zero_cnt(res_zero_cnt)
    );

    always #4 clk = ~clk;

    // Watchdog: a hung run counts as a failure and still ends with a summary.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            checks = checks + 1;
            fails = fails + 1;
            $display("FAIL watchdog: actual %0d cycles expected fewer than 150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int zeros8(input logic [7:0] b);
        int n = 0;
        for (int k = 0; k < 8; k++) if (!b[k]) n++;
        return n;
    endfunction

    task automatic fill(input logic [7:0] v);
        for (int i = 0; i < CW; i++) stim[i] = v;
    endtask

    // Drive one codeword, predict the results, and check verdict and replay.
    task automatic run_cw(input string req, input logic md, input logic [7:0] str,
                          input logic [7:0] st, input int bp);
        bit pat, others, strict, fix, e_er, rs;
        int sum, e_cnt, got, errs, k, first_bad, bad_act, bad_exp;
        logic [7:0] exp_b, held;
        bit stalled;
        rs = (md == 1'b0);
        pat = (stim[MA] == 8'h54 && stim[MB] == 8'hFF) ||
              (stim[MA] == 8'hFF && stim[MB] == 8'h54);
        others = 1'b1;
        for (int i = 0; i < DL; i++)
            if (i != MA && i != MB && stim[i] != 8'hFF) others = 1'b0;
        sum = 0;
        for (int i = 0; i < CW; i++) begin
            if (!(i < DL || (i >= SO && i < SO + SL))) continue;
            if (rs && pat && (i == MA || i == MB)) continue;
            sum += zeros8(stim[i]);
        end
        e_cnt = (sum > 255) ? 255 : sum;
        strict = rs ? (others && (pat || (stim[MA] == 8'hFF && stim[MB] == 8'hFF)))
                    : (st == 8'hFF);
        e_er = strict || (e_cnt <= int'(str));
        fix = rs && pat && others;

        mode = md;
        ecc_strength = str;
        erased_status = st;
        for (int i = 0; i < CW; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data = stim[i];
            in_first = (i == 0);
            in_last = (i == CW - 1);
            while (!in_ready) @(negedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last = 1'b0;
        chk(res_valid == 1'b1, "R3", {req, " verdict pulse"}, res_valid, 1);
        chk(res_erased == e_er, req, "erased flag", res_erased, e_er);
        chk(res_zero_cnt == e_cnt[7:0], req, "zero count", res_zero_cnt, e_cnt);
        chk(in_ready == 1'b0, "R2", "input closed during replay", in_ready, 0);

        got = 0; errs = 0; k = 0; first_bad = -1; bad_act = 0; bad_exp = 0;
        stalled = 1'b0; held = 8'd0;
        while (got < CW) begin
            if (k == 1) chk(res_valid == 1'b0, "R3", "verdict lasts one cycle", res_valid, 0);
            out_ready = (bp == 0) ? 1'b1 : ((k % bp) != 0);
            if (stalled && out_valid && out_data != held) begin
                errs++;
                if (first_bad < 0) begin first_bad = got; bad_act = out_data; bad_exp = held; end
            end
            if (out_valid && out_ready) begin
                exp_b = (fix && (got == MA || got == MB)) ? 8'hFF : stim[got];
                if (out_data != exp_b || out_first != (got == 0) || out_last != (got == CW - 1)) begin
                    errs++;
                    if (first_bad < 0) begin first_bad = got; bad_act = out_data; bad_exp = exp_b; end
                end
                got++;
                stalled = 1'b0;
            end else if (out_valid) begin
                stalled = 1'b1;
                held = out_data;
            end
            k++;
            @(negedge clk);
        end
        out_ready = 1'b0;
        if (first_bad >= 0)
            $display("  first replay mismatch at offset %0d: %0h vs %0h", first_bad, bad_act, bad_exp);
        chk(errs == 0, req, "replay mismatches (R2 order, R6/R7 markers)", errs, 0);
        chk(out_valid == 1'b0 && in_ready == 1'b1, "R2", "back to fill after replay",
            {out_valid, in_ready}, 1);
    endtask

    // Scenario R1: reset state.
    task automatic test_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(res_valid == 1'b0, "R1", "res_valid in reset", res_valid, 0);
        chk(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
        chk(res_valid == 1'b0 && out_valid == 1'b0, "R1", "outputs idle after reset",
            {res_valid, out_valid}, 0);
    endtask

    // Scenario: all ones in Reed-Solomon mode.
    task automatic test_all_ones;
        fill(8'hFF);
        run_cw("R6", 1'b0, 8'd0, 8'h00, 0);
    endtask

    // Scenario R6: marker at the first or the second offset, rest all ones.
    task automatic test_marker_pair;
        fill(8'hFF); stim[MA] = 8'h54;
        run_cw("R6", 1'b0, 8'd0, 8'h00, 0);
        fill(8'hFF); stim[MB] = 8'h54;
        run_cw("R6", 1'b0, 8'd0, 8'h00, 3);
    endtask

    // Scenario R7/R10: marker pair plus one flipped bit.
    task automatic test_marker_with_flip;
        fill(8'hFF); stim[MA] = 8'h54; stim[100] = 8'hFE;
        run_cw("R7", 1'b0, 8'd0, 8'h00, 0);
        run_cw("R10", 1'b0, 8'd1, 8'h00, 2);
    endtask

    // Scenario R8: 0x54 at both offsets does not form a marker pair.
    task automatic test_double_marker;
        fill(8'hFF); stim[MA] = 8'h54; stim[MB] = 8'h54;
        run_cw("R8", 1'b0, 8'd9, 8'h00, 0);
        run_cw("R8", 1'b0, 8'd10, 8'h00, 0);
    endtask

    // Scenario R4: excluded bytes and the usable spare window.
    task automatic test_regions;
        fill(8'hFF);
        stim[DL] = 8'h00;
        for (int i = SO + SL; i < CW; i++) stim[i] = 8'h00;
        for (int i = SO; i < SO + SL; i++) stim[i] = 8'h0F;
        run_cw("R4", 1'b1, 8'd16, 8'hFE, 0);
        run_cw("R4", 1'b1, 8'd15, 8'hFE, 0);
    endtask

    // Scenario R9: BCH mode ignores the markers and follows the status word.
    task automatic test_bch;
        fill(8'hFF); stim[MA] = 8'h54;
        run_cw("R9", 1'b1, 8'd0, 8'hFF, 0);
        run_cw("R9", 1'b1, 8'd4, 8'h7F, 4);
    endtask

    // Scenario R5: saturation of the count.
    task automatic test_saturation;
        fill(8'h00);
        run_cw("R5", 1'b1, 8'd255, 8'h00, 0);
        run_cw("R5", 1'b1, 8'd254, 8'h00, 0);
    endtask

    // Scenario: sparse pseudo-random damage with backpressure.
    task automatic test_sparse_random;
        for (int i = 0; i < CW; i++) begin
            lcg = lcg * 32'd1103515245 + 32'd12345;
            stim[i] = (lcg[20:16] == 5'd7) ? lcg[31:24] : 8'hFF;
        end
        stim[MB] = 8'h54;
        run_cw("R10", 1'b0, 8'd12, 8'h00, 5);
    endtask

    initial begin
        test_reset;
        test_all_ones;
        test_marker_pair;
        test_marker_with_flip;
        test_double_marker;
        test_regions;
        test_bch;
        test_saturation;
        test_sparse_random;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule